// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches a stream of memory and port accesses and compares each one with four programmable breakpoints. Each breakpoint has an address register and a slice of a shared 32-bit control word. That slice selects which kind of access the breakpoint reacts to and how many bytes it covers. Every access gets registered per-breakpoint hit flags one clock later. A one-cycle trap request goes up when a matching breakpoint is enabled either for the current task or for all tasks.

The control word can also lock the debug registers. While the lock is on, any register access through the register port is refused, and the refused access sets a detect flag in the status register and raises a trap. Entering the debug handler lifts the lock. A task switch wipes the per-task enables and keeps the all-task enables.

Top module: `hw_breakpoint_unit`

## Requirements
- R1: After reset, statusOut equals 32'h0001_0000, hitFlags and trapReq are 0, and the four address registers and the control word read back as 0.
- R2: accKind is encoded 00 fetch, 01 data read, 10 data write, 11 I/O. For slot n, control bits [17+4n:16+4n] select the access type: 00 hits fetches only, 01 hits data writes only, 11 hits data reads and data writes but never fetches.
- R3: Type code 10 hits I/O accesses only while extMode is 1. While extMode is 0 it never hits.
- R4: For slot n, control bits [19+4n:18+4n] give the breakpoint length: 00 means 1 byte, 01 means 2, 11 means 4, 10 means 8. The breakpoint address is aligned down to that length. accSize code s means 2^s bytes. A hit requires the access byte range to overlap the breakpoint byte range.
- R5: Control bit 2n enables slot n for the current task and bit 2n+1 enables it globally. The trap request needs a hit on a slot that has either bit set. Hits on a slot with both bits clear still appear in hitFlags and in status bits 3:0.
- R6: hitFlags, status bits 3:0 and trapReq reflect an access in the clock after accValid. The trap is a one-cycle pulse. A cycle without an access gives zero hitFlags. Each access overwrites status bits 3:0.
- R7: A taskSwitch pulse clears control bits 0, 2, 4 and 6 and leaves bits 1, 3, 5 and 7 unchanged.
- R8: While control bit 13 is 1, a register read or write has no effect, returns 0 read data, sets status bit 13 and raises trapReq in the next cycle.
- R9: A handlerEntry pulse clears control bit 13, after which register access works again.
- R10: Status bits other than 3:0 change only by a register write or by the lock event of R8.
- R11: regSel selects the register: 0 to 3 are the breakpoint addresses, 4 is status and 5 is control. Writes take effect at the clock edge, and read data appears on regRdata one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | ADDR_W | Access start byte address |
| accSize | input | 2 | Access size code, 2^code bytes |
| accKind | input | 2 | Access kind: fetch, read, write, I/O |
| extMode | input | 1 | Debug-extensions mode, enables I/O type code |
| taskSwitch | input | 1 | Task-switch pulse |
| handlerEntry | input | 1 | Debug-handler entry pulse |
| regValid | input | 1 | Register port request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regSel | input | 3 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Registered read data |
| hitFlags | output | 4 | Per-slot hit flags for the previous access |
| trapReq | output | 1 | One-cycle trap request |
| statusOut | output | 32 | Status register |

## Verification
Every combination of type code and length code is tried with all four access kinds under both values of extMode. This separates the I/O code from the undefined case and the write-only code from the read-or-write code. Accesses placed at the aligned base, just past the end, and straddling the lower edge with a 2-byte access check the alignment and overlap rules. Directed runs with only the local enable, only the global enable and neither enable separate a recorded hit from a trap. Random addresses near the breakpoints, together with random control words, are compared with a bench model of the rules.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NUM_BP = 4;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 3;
  localparam int LOCK_BIT = 13;
  localparam logic [DATA_W-1:0] LOCAL_MASK  = 32'h0000_0055;
  localparam logic [DATA_W-1:0] GLOBAL_MASK = 32'h0000_00AA;
  localparam logic [DATA_W-1:0] STATUS_INIT = 32'h0001_0000;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_IO    = 2'b11
  } accKind_e;

  typedef struct packed {
    logic [NUM_BP-1:0] wrAddr;
    logic              wrCtrl;
    logic              wrStatus;
    logic              rdEn;
    logic              lockTrap;
    logic              clrLocal;
    logic              clrLock;
  } dbgStrobe_t;
endpackage

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regValid,
  input  logic             regWrite,
  input  logic [SEL_W-1:0] regSel,
  input  logic             lockOn,
  input  logic             taskSwitch,
  input  logic             handlerEntry,
  output dbgStrobe_t       strobe
);
  logic allowed;

  always_comb begin
    strobe  = '0;
    allowed = regValid && !lockOn;
    strobe.lockTrap = regValid && lockOn;
    strobe.rdEn     = allowed && !regWrite;
    strobe.clrLocal = taskSwitch;
    strobe.clrLock  = handlerEntry;
    if (allowed && regWrite) begin
      case (regSel)
        3'd0, 3'd1, 3'd2, 3'd3: strobe.wrAddr[regSel[1:0]] = 1'b1;
        3'd4:                   strobe.wrStatus = 1'b1;
        3'd5:                   strobe.wrCtrl   = 1'b1;
        default:                ;
      endcase
    end
  end

  // R8: a locked request must never produce a write strobe
  p_locked_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && lockOn) |-> (strobe.wrAddr == '0 && !strobe.wrCtrl && !strobe.wrStatus && !strobe.rdEn));
endmodule

// File: rtl/bkpt_datapath.sv
module bkpt_datapath
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  dbgStrobe_t        strobe,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic [1:0]        accKind,
  input  logic              extMode,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic              lockOn,
  output logic [DATA_W-1:0] regRdata,
  output logic [NUM_BP-1:0] hitFlags,
  output logic              trapReq,
  output logic [DATA_W-1:0] statusOut
);
  localparam int EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] bpAddr [NUM_BP];
  logic [DATA_W-1:0] ctrlReg, ctrlNext, statusReg, statusNext, rdMux;
  logic [NUM_BP-1:0] hitNow, enMask;
  logic [EXT_W-1:0]  accLo, accEnd;
  accKind_e          kind;

  assign kind   = accKind_e'(accKind);
  assign accLo  = {1'b0, accAddr};
  assign accEnd = accLo + (EXT_W'(1) << accSize);
  assign lockOn = ctrlReg[LOCK_BIT];

  for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
    logic [1:0]       typeCode, lenCode;
    logic [EXT_W-1:0] lenBytes, base, bpEnd;
    logic             kindOk, rangeHit;

    assign typeCode = ctrlReg[16+4*i +: 2];
    assign lenCode  = ctrlReg[18+4*i +: 2];

    always_comb begin
      case (lenCode)
        2'b00:   lenBytes = EXT_W'(1);
        2'b01:   lenBytes = EXT_W'(2);
        2'b11:   lenBytes = EXT_W'(4);
        default: lenBytes = EXT_W'(8);
      endcase
      case (typeCode)
        2'b00:   kindOk = (kind == KIND_FETCH);
        2'b01:   kindOk = (kind == KIND_WRITE);
        2'b10:   kindOk = extMode && (kind == KIND_IO);
        default: kindOk = (kind == KIND_READ) || (kind == KIND_WRITE);
      endcase
    end

    assign base     = {1'b0, bpAddr[i]} & ~(lenBytes - EXT_W'(1));
    assign bpEnd    = base + lenBytes;
    assign rangeHit = (accLo < bpEnd) && (base < accEnd);
    assign hitNow[i] = rangeHit && kindOk;
    assign enMask[i] = ctrlReg[2*i] | ctrlReg[2*i+1];

    always_ff @(posedge clk) begin
      if (!rstN)                bpAddr[i] <= '0;
      else if (strobe.wrAddr[i]) bpAddr[i] <= regWdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    ctrlNext = ctrlReg;
    if (strobe.wrCtrl)   ctrlNext = regWdata;
    if (strobe.clrLocal) ctrlNext = ctrlNext & ~LOCAL_MASK;
    if (strobe.clrLock)  ctrlNext[LOCK_BIT] = 1'b0;

    statusNext = statusReg;
    if (strobe.wrStatus) statusNext = regWdata;
    if (accValid)        statusNext[NUM_BP-1:0] = hitNow;
    if (strobe.lockTrap) statusNext[LOCK_BIT] = 1'b1;

    case (regSel)
      3'd0, 3'd1, 3'd2, 3'd3: rdMux = DATA_W'(bpAddr[regSel[1:0]]);
      3'd4:                   rdMux = statusReg;
      3'd5:                   rdMux = ctrlReg;
      default:                rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      statusReg <= STATUS_INIT;
      hitFlags  <= '0;
      trapReq   <= 1'b0;
      regRdata  <= '0;
    end else begin
      ctrlReg   <= ctrlNext;
      statusReg <= statusNext;
      hitFlags  <= accValid ? hitNow : '0;
      trapReq   <= (accValid && |(hitNow & enMask)) || strobe.lockTrap;
      if (strobe.rdEn)          regRdata <= rdMux;
      else if (strobe.lockTrap) regRdata <= '0;
    end
  end

  assign statusOut = statusReg;

  // R6: no access means no hit flags in the following cycle
  p_idle_no_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (hitFlags == '0));
  // R5: a trap must be explained by a hit or a locked register access
  p_trap_has_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!accValid && !strobe.lockTrap) |=> !trapReq);
  // R7: task switch wipes local enables
  p_task_clears_local_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrLocal |=> ((ctrlReg & LOCAL_MASK) == '0));
  // R7: task switch keeps global enables
  p_task_keeps_global_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrLocal && !strobe.wrCtrl) |=> ((ctrlReg & GLOBAL_MASK) == $past(ctrlReg & GLOBAL_MASK)));
  // R9: handler entry unlocks
  p_handler_unlocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrLock |=> !lockOn);
  // R8: a locked access sets the detect flag and traps
  p_lock_trap_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockTrap |=> (statusReg[LOCK_BIT] && trapReq));
endmodule

// File: rtl/hw_breakpoint_unit.sv
module hw_breakpoint_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic [1:0]        accKind,
  input  logic              extMode,
  input  logic              taskSwitch,
  input  logic              handlerEntry,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [3:0]        hitFlags,
  output logic              trapReq,
  output logic [31:0]       statusOut
);
  dbgStrobe_t strobe;
  logic       lockOn;

  bkpt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regSel(regSel), .lockOn(lockOn), .taskSwitch(taskSwitch),
    .handlerEntry(handlerEntry), .strobe(strobe)
  );

  bkpt_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .accValid(accValid),
    .accAddr(accAddr), .accSize(accSize), .accKind(accKind), .extMode(extMode),
    .regSel(regSel), .regWdata(regWdata), .lockOn(lockOn), .regRdata(regRdata),
    .hitFlags(hitFlags), .trapReq(trapReq), .statusOut(statusOut)
  );
endmodule

// File: tb/hw_breakpoint_unit_bench.sv
module hw_breakpoint_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accSize = '0;
  logic [1:0]  accKind = '0;
  logic        extMode = 1'b0;
  logic        taskSwitch = 1'b0;
  logic        handlerEntry = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  hitFlags;
  logic        trapReq;
  logic [31:0] statusOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] mAddr [4];
  logic [31:0] mCtrl;
  logic [31:0] mStatus;

  always #2.5 clk = ~clk;

  hw_breakpoint_unit u_hw_breakpoint_unit (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accSize(accSize), .accKind(accKind), .extMode(extMode),
    .taskSwitch(taskSwitch), .handlerEntry(handlerEntry), .regValid(regValid),
    .regWrite(regWrite), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .hitFlags(hitFlags), .trapReq(trapReq),
    .statusOut(statusOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic slotHit(input int n, input logic [31:0] a, input logic [1:0] sz,
                                   input logic [1:0] k, input logic ext);
    logic [1:0] t, l;
    logic [32:0] span, lo, hi, aLo, aHi;
    logic kOk;
    t = mCtrl[16+4*n +: 2];
    l = mCtrl[18+4*n +: 2];
    span = (l == 2'b00) ? 33'd1 : (l == 2'b01) ? 33'd2 : (l == 2'b11) ? 33'd4 : 33'd8;
    lo = {1'b0, mAddr[n]} - ({1'b0, mAddr[n]} % span);
    hi = lo + span;
    aLo = {1'b0, a};
    aHi = aLo + (33'd1 << sz);
    if (t == 2'b00)      kOk = (k == 2'b00);
    else if (t == 2'b01) kOk = (k == 2'b10);
    else if (t == 2'b11) kOk = (k == 2'b01) || (k == 2'b10);
    else                 kOk = ext && (k == 2'b11);
    return kOk && !(aHi <= lo) && !(hi <= aLo);
  endfunction

  task automatic regWr(input logic [2:0] sel, input logic [31:0] d, input string tag);
    logic locked;
    locked = mCtrl[13];
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    if (locked) mStatus[13] = 1'b1;
    else if (sel < 3'd4) mAddr[sel[1:0]] = d;
    else if (sel == 3'd4) mStatus = d;
    else if (sel == 3'd5) mCtrl = d;
    check({tag, " trap after register write"}, 32'(trapReq), 32'(locked));
  endtask

  task automatic regRd(input logic [2:0] sel, input string tag);
    logic [31:0] e;
    logic locked;
    locked = mCtrl[13];
    e = (sel < 3'd4) ? mAddr[sel[1:0]] : (sel == 3'd4) ? mStatus : (sel == 3'd5) ? mCtrl : 32'h0;
    if (locked) e = 32'h0;
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regSel = sel;
    @(negedge clk);
    regValid = 1'b0;
    if (locked) mStatus[13] = 1'b1;
    check({tag, " read data"}, regRdata, e);
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] k,
                        input logic ext, input string tag);
    logic [3:0] eh;
    logic et;
    for (int n = 0; n < 4; n++) eh[n] = slotHit(n, a, sz, k, ext);
    et = 1'b0;
    for (int n = 0; n < 4; n++) if (eh[n] && (mCtrl[2*n] || mCtrl[2*n+1])) et = 1'b1;
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accSize = sz; accKind = k; extMode = ext;
    @(negedge clk);
    accValid = 1'b0;
    mStatus[3:0] = eh;
    check({tag, " hitFlags"}, 32'(hitFlags), 32'(eh));
    check({tag, " trapReq"}, 32'(trapReq), 32'(et));
    check({tag, " status"}, statusOut, mStatus);
  endtask

  task automatic pulse(input bit isTask);
    @(negedge clk);
    if (isTask) taskSwitch = 1'b1; else handlerEntry = 1'b1;
    @(negedge clk);
    taskSwitch = 1'b0; handlerEntry = 1'b0;
    if (isTask) mCtrl = mCtrl & ~32'h55; else mCtrl[13] = 1'b0;
  endtask

  initial begin
    repeat (1500000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] rv;
    seed = 12345;
    rv = $urandom(seed);
    for (int n = 0; n < 4; n++) mAddr[n] = '0;
    mCtrl = '0;
    mStatus = 32'h0001_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status reset", statusOut, 32'h0001_0000);
    check("R1 hitFlags reset", 32'(hitFlags), 32'h0);
    check("R1 trapReq reset", 32'(trapReq), 32'h0);
    for (int n = 0; n < 6; n++) regRd(3'(n), "R1 R11 reset register");

    // R2 R3 R4: every type and length code with all kinds and both modes
    regWr(3'd0, 32'h0000_1005, "R11");
    for (int t = 0; t < 4; t++) begin
      for (int l = 0; l < 4; l++) begin
        regWr(3'd5, 32'h2 | (32'(t) << 16) | (32'(l) << 18), "R11 ctrl");
        for (int k = 0; k < 4; k++) begin
          for (int e = 0; e < 2; e++) begin
            access(32'h0000_1000, 2'd0, 2'(k), 1'(e), "R2 R3 base byte");
            access(32'h0000_1008, 2'd0, 2'(k), 1'(e), "R4 past end");
          end
        end
      end
    end

    // R4 alignment and overlap
    regWr(3'd1, 32'h0000_2003, "R11");
    regWr(3'd5, 32'h0000_0008 | (32'b11_01 << 20), "R11 ctrl");
    access(32'h0000_2000, 2'd0, 2'b10, 1'b0, "R4 aligned base");
    access(32'h0000_1FFF, 2'd1, 2'b10, 1'b0, "R4 straddle low edge");
    access(32'h0000_1FFE, 2'd1, 2'b10, 1'b0, "R4 just below");
    access(32'h0000_1FF8, 2'd3, 2'b10, 1'b0, "R4 8-byte access below");

    // R5 enables: local only, global only, none
    regWr(3'd5, 32'h0000_0004 | (32'b11_01 << 20), "R5 local");
    access(32'h0000_2001, 2'd0, 2'b10, 1'b0, "R5 local enable");
    regWr(3'd5, 32'h0000_0000 | (32'b11_01 << 20), "R5 none");
    access(32'h0000_2001, 2'd0, 2'b10, 1'b0, "R5 no enable hit recorded");
    // R6 trap is a single pulse and idle clears flags
    regWr(3'd5, 32'h0000_0008 | (32'b11_01 << 20), "R6 global");
    access(32'h0000_2002, 2'd0, 2'b10, 1'b0, "R6 trap access");
    @(negedge clk);
    check("R6 trap one cycle", 32'(trapReq), 32'h0);
    check("R6 idle hitFlags", 32'(hitFlags), 32'h0);
    access(32'h0000_9000, 2'd0, 2'b10, 1'b0, "R6 miss overwrites status");

    // R7 task switch
    regWr(3'd5, 32'h5555_00FF, "R7 setup");
    pulse(1'b1);
    regRd(3'd5, "R7 locals cleared globals kept");

    // R8 R9 lock
    regWr(3'd5, 32'h0000_2000, "R8 lock on");
    regWr(3'd1, 32'hDEAD_BEEF, "R8 blocked write");
    check("R8 detect flag", 32'(statusOut[13]), 32'h1);
    regRd(3'd5, "R8 blocked read");
    pulse(1'b0);
    regRd(3'd1, "R9 address unchanged after unlock");
    regRd(3'd5, "R9 lock cleared");

    // R10 sticky status bits survive accesses
    access(32'h0000_0000, 2'd0, 2'b00, 1'b0, "R10 access keeps bit13");
    check("R10 bit13 sticky", 32'(statusOut[13]), 32'h1);
    regWr(3'd4, 32'h0, "R10 software clear");
    check("R10 cleared", statusOut, 32'h0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      if (it % 20 == 0) begin
        for (int n = 0; n < 4; n++) regWr(3'(n), 32'h3000 + ($urandom % 32), "R11 random addr");
        regWr(3'd5, $urandom & 32'hFFFF_DFFF, "R11 random ctrl");
      end
      access(32'h3000 + ($urandom % 40), 2'($urandom), 2'($urandom), 1'($urandom), "R2 R4 R5 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule